// File: doc/BRIEF.md
# Scaler Setup Factor Calculator

This block turns a window's source size and its destination size into the setup values that a display scaler needs before it starts. It is given source and destination width and height and a flag that marks YUV content. From these it derives the scaling direction for each axis and the vertical line-skip count used when shrinking. It also picks a line-buffer arrangement from the source width and works out a 16-bit fixed-point step factor for each axis.

Software or a configuration sequencer loads the four sizes and the flag and raises `start` for one cycle while the block is idle. The block samples the inputs at that edge. Two restoring dividers then run side by side, one for each axis, and each produces one quotient bit per cycle. When both dividers have finished, every result is updated in the same edge and `done` pulses once. The results then hold until the next run completes.

Top module: `scl_cfg_calc`

## Requirements
- R1: Each axis reports its direction as a 2-bit code. The code is 0 when source equals destination, 1 when source is less than destination (growing), and 2 when source is greater than destination (shrinking). Code 3 never appears.
- R2: The vertical skip count `vskip` is 4 when src_h >= 4*dst_h, otherwise 2 when src_h >= 2*dst_h, otherwise 1. A growing vertical axis therefore always reports 1.
- R3: When the vertical axis shrinks, its factor uses the reduced height ceil(src_h / vskip) in place of src_h.
- R4: The factor numerator depends on the axis direction. Shrinking uses (2*s-3)*2^11, growing uses (2*s-3)*2^15, and equal sizes use (s-1)*2^12. The numerator is divided by (dst-1), and the output is the low 16 bits of the integer quotient.
- R5: When 2*s is less than 3, the numerator of a shrinking or growing axis is 0. The same holds for s = 0 on an equal axis.
- R6: `lb_mode` is 2 when src_w > 2560, else 3 when src_w > 1920, else 4 when the YUV flag is 0, else 0 when src_w > 1280, else 1.
- R7: When an axis has dst <= 1, its factor is 0 and its bit in `div_err` is set (bit 0 horizontal, bit 1 vertical). Otherwise that bit is 0.
- R8: `done` is high for exactly one cycle, NUM_W+2 rising edges after the edge that samples `start`, where NUM_W = SIZE_W+16. `busy` is high from the edge after sampling until the edge that raises `done`.
- R9: A `start` raised while `busy` is high has no effect. Neither the inputs nor the timing of the run in progress change.
- R10: Reset clears every result output, `busy` and `done` to 0. Results change only at the edge that raises `done` and otherwise hold, even when the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a calculation; sampled only while idle |
| src_w | input | SIZE_W | Source width |
| src_h | input | SIZE_W | Source height |
| dst_w | input | SIZE_W | Destination width |
| dst_h | input | SIZE_W | Destination height |
| yuv_in | input | 1 | Source content is YUV |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse when results update |
| hmode | output | 2 | Horizontal direction code |
| vmode | output | 2 | Vertical direction code |
| vskip | output | 3 | Vertical line-skip count (1, 2 or 4) |
| lb_mode | output | 3 | Line-buffer arrangement code |
| hfactor | output | 16 | Horizontal step factor |
| vfactor | output | 16 | Vertical step factor |
| div_err | output | 2 | Zero-divisor flag per axis (bit 0 horizontal) |

## Verification
Every result, including the direction codes, the skip count and the line-buffer code, is due in the cycle in which `done` is high. That cycle follows the edge that is NUM_W+2 edges after the sampling edge, which is 31 edges with the default width. The bench counts rising edges from the sampling edge, checks that the count of edges seen when `done` first reads high is exactly that figure, and samples all outputs on the falling edge of that same cycle. One cycle later it confirms that `done` has fallen. For the ignored-start and hold cases, it samples again only after the edge at which a wrong update could have appeared.

// File: rtl/scl_cfg_pkg.sv
package scl_cfg_pkg;

  typedef enum logic [1:0] {
    DIR_KEEP   = 2'd0,
    DIR_GROW   = 2'd1,
    DIR_SHRINK = 2'd2
  } scl_dir_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2
  } scl_state_e;

  // direction of one axis
  function automatic scl_dir_e dir_of(input int unsigned s, input int unsigned d);
    if (s < d)      return DIR_GROW;
    else if (s > d) return DIR_SHRINK;
    return DIR_KEEP;
  endfunction

  // power-of-two line skip, largest first
  function automatic logic [2:0] skip_of(input int unsigned s, input int unsigned d);
    if (s >= 4 * d)      return 3'd4;
    else if (s >= 2 * d) return 3'd2;
    return 3'd1;
  endfunction

  // rows left after skipping, rounded up
  function automatic int unsigned eff_rows(input int unsigned s, input logic [2:0] k);
    int unsigned sh;
    sh = k[2] ? 2 : (k[1] ? 1 : 0);
    return (s + 32'(k) - 1) >> sh;
  endfunction

  // line-buffer arrangement from width thresholds
  function automatic logic [2:0] lb_of(input int unsigned w, input logic yuv);
    if (w > 2560)      return 3'd2;
    else if (w > 1920) return 3'd3;
    else if (!yuv)     return 3'd4;
    else if (w > 1280) return 3'd0;
    return 3'd1;
  endfunction

  // offset fixed-point numerator
  function automatic int unsigned numer_of(input scl_dir_e dir, input int unsigned s);
    int unsigned base;
    case (dir)
      DIR_SHRINK, DIR_GROW: begin
        base = (2 * s < 3) ? 0 : (2 * s - 3);
        return (dir == DIR_SHRINK) ? (base << 11) : (base << 15);
      end
      default: return (s == 0) ? 0 : ((s - 1) << 12);
    endcase
  endfunction

endpackage

// File: rtl/scl_cfg_div.sv
module scl_cfg_div #(
  parameter int NW = 29,
  parameter int DW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic [NW-1:0] quo,
  output logic          fin
);
  localparam int CNT_W = $clog2(NW + 1);

  logic [DW-1:0]    rem_q;
  logic [NW-1:0]    quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  logic [DW:0]   shifted;
  logic [DW+1:0] trial;
  logic          take_bit;

  assign shifted  = {rem_q, quo_q[NW-1]};
  assign trial    = {1'b0, shifted} - {2'b00, den};
  assign take_bit = ~trial[DW+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= num;
      cnt_q <= CNT_W'(NW);
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q != '0) begin
        rem_q <= take_bit ? trial[DW-1:0] : shifted[DW-1:0];
        quo_q <= {quo_q[NW-2:0], take_bit};
        cnt_q <= cnt_q - 1'b1;
      end else begin
        act_q <= 1'b0;
      end
    end
  end

  assign quo = quo_q;
  assign fin = act_q && (cnt_q == '0);
endmodule

// File: rtl/scl_cfg_setup.sv
module scl_cfg_setup
  import scl_cfg_pkg::*;
#(
  parameter int SIZE_W = 13,
  parameter int NUM_W  = SIZE_W + 16
) (
  input  logic [SIZE_W-1:0]          sw,
  input  logic [SIZE_W-1:0]          sh,
  input  logic [SIZE_W-1:0]          dw,
  input  logic [SIZE_W-1:0]          dh,
  input  logic                       yuv,
  output scl_dir_e                   hdir,
  output scl_dir_e                   vdir,
  output logic [2:0]                 skip,
  output logic [2:0]                 lb,
  output logic [1:0][NUM_W-1:0]      num,
  output logic [1:0][SIZE_W-1:0]     den,
  output logic [1:0]                 zden
);
  int unsigned vrows;

  always_comb begin
    hdir  = dir_of(32'(sw), 32'(dw));
    vdir  = dir_of(32'(sh), 32'(dh));
    skip  = skip_of(32'(sh), 32'(dh));
    lb    = lb_of(32'(sw), yuv);
    vrows = (vdir == DIR_SHRINK) ? eff_rows(32'(sh), skip) : 32'(sh);
    num[0] = NUM_W'(numer_of(hdir, 32'(sw)));
    num[1] = NUM_W'(numer_of(vdir, vrows));
    den[0] = dw - SIZE_W'(1);
    den[1] = dh - SIZE_W'(1);
    zden[0] = dw < SIZE_W'(2);
    zden[1] = dh < SIZE_W'(2);
  end
endmodule

// File: rtl/scl_cfg_calc.sv
module scl_cfg_calc
  import scl_cfg_pkg::*;
#(
  parameter int SIZE_W = 13,
  parameter int FAC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SIZE_W-1:0] src_w,
  input  logic [SIZE_W-1:0] src_h,
  input  logic [SIZE_W-1:0] dst_w,
  input  logic [SIZE_W-1:0] dst_h,
  input  logic              yuv_in,
  output logic              busy,
  output logic              done,
  output logic [1:0]        hmode,
  output logic [1:0]        vmode,
  output logic [2:0]        vskip,
  output logic [2:0]        lb_mode,
  output logic [FAC_W-1:0]  hfactor,
  output logic [FAC_W-1:0]  vfactor,
  output logic [1:0]        div_err
);
  localparam int NUM_W = SIZE_W + 16;
  localparam int AXES  = 2;

  scl_state_e state_q;
  logic [SIZE_W-1:0] sw_q, sh_q, dw_q, dh_q;
  logic yuv_q;

  scl_dir_e hdir, vdir;
  logic [2:0] skip, lb;
  logic [AXES-1:0][NUM_W-1:0]  num;
  logic [AXES-1:0][SIZE_W-1:0] den;
  logic [AXES-1:0]             zden;
  logic [AXES-1:0][NUM_W-1:0]  quo;
  logic [AXES-1:0]             fin;

  // named events
  logic take_ev, load_ev, finish_ev;
  assign take_ev   = start && (state_q == ST_IDLE);
  assign load_ev   = (state_q == ST_LOAD);
  assign finish_ev = (state_q == ST_RUN) && (&fin);

  scl_cfg_setup #(.SIZE_W(SIZE_W), .NUM_W(NUM_W)) u_setup (
    .sw(sw_q), .sh(sh_q), .dw(dw_q), .dh(dh_q), .yuv(yuv_q),
    .hdir(hdir), .vdir(vdir), .skip(skip), .lb(lb),
    .num(num), .den(den), .zden(zden)
  );

  for (genvar g = 0; g < AXES; g++) begin : g_axis
    scl_cfg_div #(.NW(NUM_W), .DW(SIZE_W)) u_div (
      .clk(clk), .rst_n(rst_n), .load(load_ev),
      .num(num[g]), .den(den[g]), .quo(quo[g]), .fin(fin[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sw_q <= '0; sh_q <= '0; dw_q <= '0; dh_q <= '0; yuv_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (take_ev) begin
          sw_q <= src_w; sh_q <= src_h; dw_q <= dst_w; dh_q <= dst_h;
          yuv_q <= yuv_in;
          state_q <= ST_LOAD;
        end
        ST_LOAD: state_q <= ST_RUN;
        ST_RUN:  if (finish_ev) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      hmode <= '0; vmode <= '0; vskip <= '0; lb_mode <= '0;
      hfactor <= '0; vfactor <= '0; div_err <= '0;
    end else begin
      done <= finish_ev;
      if (finish_ev) begin
        hmode   <= hdir;
        vmode   <= vdir;
        vskip   <= skip;
        lb_mode <= lb;
        hfactor <= zden[0] ? '0 : quo[0][FAC_W-1:0];
        vfactor <= zden[1] ? '0 : quo[1][FAC_W-1:0];
        div_err <= zden;
      end
    end
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/scl_cfg_calc_chk.sv
module scl_cfg_calc_chk #(
  parameter int SIZE_W = 13,
  parameter int FAC_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [1:0]        hmode,
  input logic [1:0]        vmode,
  input logic [2:0]        vskip,
  input logic [2:0]        lb_mode,
  input logic [FAC_W-1:0]  hfactor,
  input logic [FAC_W-1:0]  vfactor,
  input logic [1:0]        div_err,
  input logic [SIZE_W-1:0] cap_sw,
  input logic [SIZE_W-1:0] cap_sh,
  input logic [SIZE_W-1:0] cap_dw,
  input logic [SIZE_W-1:0] cap_dh
);
  p_mode_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hmode != 2'd3 && vmode != 2'd3));

  p_skip_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(vskip) == 1));

  p_grow_noskip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && vmode == 2'd1) |-> (vskip == 3'd1));

  p_lb_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lb_mode <= 3'd4));

  p_herr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_err[0]) |-> (hfactor == '0));

  p_verr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_err[1]) |-> (vfactor == '0));

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cap_sw) && $stable(cap_sh) && $stable(cap_dw) && $stable(cap_dh)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(hfactor) || !$stable(vfactor) || !$stable(div_err)) |-> done);
endmodule

bind scl_cfg_calc scl_cfg_calc_chk #(.SIZE_W(SIZE_W), .FAC_W(FAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .hmode(hmode), .vmode(vmode), .vskip(vskip), .lb_mode(lb_mode),
  .hfactor(hfactor), .vfactor(vfactor), .div_err(div_err),
  .cap_sw(sw_q), .cap_sh(sh_q), .cap_dw(dw_q), .cap_dh(dh_q)
);

// File: tb/scl_cfg_calc_bench.sv
module scl_cfg_calc_bench;
  localparam int SIZE_W = 13;
  localparam int LAT = SIZE_W + 16 + 3;  // edges counted including the sampling edge
  localparam int NV = 10;

  typedef struct packed {
    logic [12:0] sw, sh, dw, dh;
    logic        yuv;
    logic [1:0]  hm, vm;
    logic [2:0]  sk, lb;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{13'd1920, 13'd1080, 13'd1920, 13'd1080, 1'b0, 2'd0, 2'd0, 3'd1, 3'd4},
    '{13'd3840, 13'd2160, 13'd1280, 13'd720,  1'b0, 2'd2, 2'd2, 3'd2, 3'd2},
    '{13'd1280, 13'd720,  13'd1920, 13'd1080, 1'b1, 2'd1, 2'd1, 3'd1, 3'd1},
    '{13'd2000, 13'd4000, 13'd1000, 13'd1000, 1'b1, 2'd2, 2'd2, 3'd4, 3'd3},
    '{13'd1600, 13'd900,  13'd800,  13'd1200, 1'b1, 2'd2, 2'd1, 3'd1, 3'd0},
    '{13'd2561, 13'd100,  13'd2561, 13'd1,    1'b0, 2'd0, 2'd2, 3'd4, 3'd2},
    '{13'd1281, 13'd10,   13'd640,  13'd3,    1'b1, 2'd2, 2'd2, 3'd2, 3'd0},
    '{13'd1280, 13'd1,    13'd1280, 13'd2,    1'b1, 2'd0, 2'd1, 3'd1, 3'd1},
    '{13'd1921, 13'd8,    13'd1921, 13'd2,    1'b0, 2'd0, 2'd2, 3'd4, 3'd3},
    '{13'd4000, 13'd300,  13'd100,  13'd300,  1'b0, 2'd2, 2'd0, 3'd1, 3'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [12:0] src_w = '0, src_h = '0, dst_w = '0, dst_h = '0;
  logic yuv_in = 1'b0;
  logic busy, done;
  logic [1:0] hmode, vmode, div_err;
  logic [2:0] vskip, lb_mode;
  logic [15:0] hfactor, vfactor;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  scl_cfg_calc u_scl_cfg_calc (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h), .yuv_in(yuv_in),
    .busy(busy), .done(done), .hmode(hmode), .vmode(vmode), .vskip(vskip),
    .lb_mode(lb_mode), .hfactor(hfactor), .vfactor(vfactor), .div_err(div_err)
  );

  task automatic check_eq(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // factor from the requirement text (R3, R4, R5, R7)
  function automatic longint exp_fac(input longint s, input longint d, input bit vert, input longint k);
    longint eff, num;
    if (d <= 1) return 0;
    eff = s;
    if (vert && s > d) eff = (s + k - 1) / k;
    if (s > d)      num = (2 * eff < 3) ? 0 : (2 * eff - 3) * 2048;
    else if (s < d) num = (2 * eff < 3) ? 0 : (2 * eff - 3) * 32768;
    else            num = (eff == 0) ? 0 : (eff - 1) * 4096;
    return (num / (d - 1)) % 65536;
  endfunction

  task automatic drive(input vec_t v);
    src_w = v.sw; src_h = v.sh; dst_w = v.dw; dst_h = v.dh; yuv_in = v.yuv;
  endtask

  // raise start, count edges until done reads high
  task automatic launch(input vec_t v, output int n);
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(posedge clk);
    n = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 200) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_results(input vec_t v, input string id);
    check_eq({"R1 hmode ", id}, hmode, v.hm);
    check_eq({"R1 vmode ", id}, vmode, v.vm);
    check_eq({"R2 vskip ", id}, vskip, v.sk);
    check_eq({"R6 lb_mode ", id}, lb_mode, v.lb);
    check_eq({"R4 hfactor ", id}, hfactor, exp_fac(v.sw, v.dw, 1'b0, 1));
    check_eq({"R3 vfactor ", id}, vfactor, exp_fac(v.sh, v.dh, 1'b1, longint'(v.sk)));
    check_eq({"R7 div_err ", id}, div_err, {v.dh <= 1, v.dw <= 1});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [15:0] hold_h, hold_v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check_eq("R10 reset done", done, 0);
    check_eq("R10 reset busy", busy, 0);
    check_eq("R10 reset hfactor", hfactor, 0);
    check_eq("R10 reset vfactor", vfactor, 0);
    check_eq("R10 reset div_err", div_err, 0);

    for (int i = 0; i < NV; i++) begin
      launch(VEC[i], n);
      check_eq($sformatf("R8 latency v%0d", i), n, LAT);
      check_results(VEC[i], $sformatf("v%0d", i));
      @(negedge clk);
      check_eq($sformatf("R8 pulse v%0d", i), done, 0);
    end

    // R10: inputs change without start, results hold
    hold_h = hfactor;
    hold_v = vfactor;
    drive(VEC[0]);
    repeat (6) @(negedge clk);
    check_eq("R10 hold hfactor", hfactor, hold_h);
    check_eq("R10 hold vfactor", vfactor, hold_v);
    check_eq("R10 hold busy", busy, 0);

    // R9: start during busy ignored
    @(negedge clk);
    drive(VEC[1]);
    start = 1'b1;
    @(posedge clk);
    n = 1;
    @(negedge clk);
    start = 1'b0;
    check_eq("R8 busy after start", busy, 1);
    repeat (4) begin @(posedge clk); n++; @(negedge clk); end
    drive(VEC[4]);
    start = 1'b1;
    @(posedge clk); n++;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 200) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    check_eq("R9 latency unchanged", n, LAT);
    check_results(VEC[1], "R9 run");
    @(negedge clk);
    check_eq("R9 no second run busy", busy, 0);
    repeat (LAT + 2) @(negedge clk);
    check_eq("R9 no second done hfactor", hfactor, exp_fac(VEC[1].sw, VEC[1].dw, 1'b0, 1));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule